// File: doc/BRIEF.md
# Bus-Matching Byte-Swap Read Port

This block is the read side of one FIFO port whose storage is organised as 36-bit long words made of four 9-bit lanes. On each clocked read it hands the reader either a whole long word, one of the two 18-bit halves, or one of the four 9-bit lanes. It works through the head long word piece by piece and asks the FIFO to pop that word only when the last piece has been read. The FIFO output is show-ahead: the head word stays on `fifo_q` until a pop is accepted.

The lane order of each long word may be rearranged by one of four swap patterns. The pattern is chosen at the first piece of a long word and held for that word's remaining pieces, so it works with every bus width. The bus width and the piece order are registered on one rising clock edge and take effect on the next one. One width code sends the read to a 36-bit mailbox register instead of the FIFO.

Top module: `bmatch_rd_port`

## Requirements
- R1: A synchronous active-high reset clears the piece position to the first piece, makes long word the width in force and selects least-significant-first order, whatever `size_sel` and `big_end` hold at the time. The first read after reset is therefore a full long-word read.
- R2: `size_sel` and `big_end` are sampled on a rising edge and come into force on the following rising edge. Reads before that second edge still use the old settings.
- R3: Long-word width (`size_sel`=00) returns the whole swapped head word on `rd_data`, and every read raises `fifo_pop`.
- R4: Word width (`size_sel`=01) returns an 18-bit half on `rd_data[17:0]` with bits 35:18 zero. Two reads consume one long word, and `fifo_pop` is raised only on the second read.
- R5: Byte width (`size_sel`=10) returns one 9-bit lane on `rd_data[8:0]` with bits 35:9 zero. Four reads consume one long word, and `fifo_pop` is raised only on the fourth read.
- R6: With `big_end`=1 the pieces are returned most significant first: the upper half, or lane 3 (bits 35:27), comes first. With `big_end`=0 the lower half, or lane 0 (bits 8:0), comes first.
- R7: Lanes are numbered 0 to 3 at bits 8:0, 17:9, 26:18 and 35:27. `swap_sel` selects which input lane feeds each output lane. 00 keeps the order. 11 reverses all four lanes. 10 exchanges the two 18-bit halves. 01 exchanges the two lanes inside each half. In every case output lane i takes input lane i XOR `swap_sel`.
- R8: The swap pattern is taken from `swap_sel` at the first piece of each long word. Changes to `swap_sel` during the remaining pieces of that word have no effect.
- R9: Width code 11 reads the mailbox. `rd_data` carries `mbox_q` unswapped, `mbox_rd` follows `rd_en`, and `fifo_pop` stays low. The FIFO piece position and the held swap pattern are unchanged, so a later FIFO read resumes at the next piece.
- R10: With `rd_en` low, `fifo_pop` and `mbox_rd` stay low and the piece position does not advance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock, rising-edge active |
| rst | input | 1 | Synchronous active-high reset |
| size_sel | input | 2 | Width code: 00 long word, 01 word, 10 byte, 11 mailbox |
| big_end | input | 1 | 1 returns the most significant piece first |
| swap_sel | input | 2 | Lane swap pattern, sampled at the first piece of a long word |
| rd_en | input | 1 | Read strobe, one read per rising edge while high |
| fifo_q | input | 36 | Head long word of the FIFO (show-ahead) |
| mbox_q | input | 36 | Mailbox register contents |
| rd_data | output | 36 | Read data, narrow pieces right-aligned and zero-extended |
| fifo_pop | output | 1 | Pop request for the FIFO head, raised on the last piece of a long word |
| mbox_rd | output | 1 | Mailbox read strobe |

## Verification
The hardest case to reach from the ports is a long word that is left part-read. This happens when the width changes mid-word, when a mailbox access is inserted between pieces, or when `swap_sel` changes after the first piece. In each case the held piece position and the held swap pattern must survive. The stimulus reaches it through random runs of one to six reads per width setting, so words are often abandoned or overrun, with a new random `swap_sel` on every read. Directed sequences add a mailbox access between byte reads, a reset in the middle of a byte sequence, and a width change issued together with a read to pin down the two-edge latency.

// File: rtl/bmrd_pkg.sv
package bmrd_pkg;

    localparam int LANE_W  = 9;
    localparam int LANES   = 4;
    localparam int LONG_W  = LANE_W * LANES;
    localparam int HALF_W  = LONG_W / 2;
    localparam int IDX_W   = $clog2(LANES);

    typedef enum logic [1:0] {
        SZ_LONG = 2'b00,
        SZ_WORD = 2'b01,
        SZ_BYTE = 2'b10,
        SZ_MBOX = 2'b11
    } size_e;

    typedef logic [IDX_W-1:0] swap_t;
    typedef logic [IDX_W-1:0] idx_t;

    typedef struct packed {
        size_e size;
        logic  big_end;
    } ctl_t;

    localparam ctl_t CTL_RESET = '{size: SZ_LONG, big_end: 1'b0};

    // index of the final piece of a long word for a given width
    function automatic idx_t last_piece(input size_e sz);
        case (sz)
            SZ_WORD: last_piece = idx_t'(1);
            SZ_BYTE: last_piece = idx_t'(LANES - 1);
            default: last_piece = idx_t'(0);
        endcase
    endfunction

endpackage

// File: rtl/bmrd_ctl_sample.sv
module bmrd_ctl_sample
    import bmrd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] size_sel,
    input  logic       big_end,
    output ctl_t       ctl_act
);

    ctl_t ctl_smp;

    // first edge captures the request, second edge puts it in force
    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_smp <= CTL_RESET;
            ctl_act <= CTL_RESET;
        end else begin
            ctl_smp <= '{size: size_e'(size_sel), big_end: big_end};
            ctl_act <= ctl_smp;
        end
    end

    // R2: the setting in force never jumps straight to a fresh input
    p_two_edge_r2: assert property (@(posedge clk) disable iff (rst)
        (ctl_act != $past(ctl_act)) |-> (ctl_act == $past(ctl_smp)));

endmodule

// File: rtl/bmrd_seq.sv
module bmrd_seq
    import bmrd_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  rd_en,
    input  ctl_t  ctl_act,
    input  swap_t swap_sel,
    output idx_t  idx,
    output swap_t swap_eff,
    output logic  fifo_pop,
    output logic  mbox_rd
);

    swap_t swap_hold;
    logic  is_mbox;
    logic  first;
    logic  last;

    always_comb begin
        is_mbox  = (ctl_act.size == SZ_MBOX);
        first    = (idx == '0);
        last     = (idx >= last_piece(ctl_act.size));
        swap_eff = first ? swap_sel : swap_hold;
        fifo_pop = rd_en && !is_mbox && last;
        mbox_rd  = rd_en && is_mbox;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx       <= '0;
            swap_hold <= '0;
        end else if (rd_en && !is_mbox) begin
            idx <= last ? '0 : idx + idx_t'(1);
            if (first) begin
                swap_hold <= swap_sel;
            end
        end
    end

    // R10: no strobe, no movement
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(idx));

    // R5: after a pop the next read begins a fresh long word
    p_wrap_r5: assert property (@(posedge clk) disable iff (rst)
        fifo_pop |=> (idx == '0));

    // R5: a byte-width pop only on the fourth lane
    p_byte_last_r5: assert property (@(posedge clk) disable iff (rst)
        (fifo_pop && ctl_act.size == SZ_BYTE) |-> (idx == idx_t'(LANES - 1)));

    // R4: the second word read always pops
    p_word_pop_r4: assert property (@(posedge clk) disable iff (rst)
        (rd_en && ctl_act.size == SZ_WORD && idx == idx_t'(1)) |-> fifo_pop);

    // R8: the pattern used for later pieces is the one seen at the first piece
    p_swap_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !is_mbox && first && !last) |=> (swap_eff == $past(swap_sel)));

    // R9: mailbox reads leave the FIFO position alone
    p_mbox_idx_r9: assert property (@(posedge clk) disable iff (rst)
        mbox_rd |=> $stable(idx));

endmodule

// File: rtl/bmrd_lane_mux.sv
module bmrd_lane_mux
    import bmrd_pkg::*;
(
    input  logic [LONG_W-1:0] fifo_q,
    input  logic [LONG_W-1:0] mbox_q,
    input  swap_t             swap_eff,
    input  ctl_t              ctl_act,
    input  idx_t              idx,
    output logic [LONG_W-1:0] rd_data
);

    logic [LANE_W-1:0] lane_in  [LANES];
    logic [LANE_W-1:0] lane_out [LANES];
    logic [LONG_W-1:0] swapped;
    logic [HALF_W-1:0] half_pick;
    logic [LANE_W-1:0] lane_pick;
    logic              half_sel;
    idx_t              lane_sel;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_in[i] = fifo_q[i*LANE_W +: LANE_W];
        // each output lane takes the input lane at its index XOR the pattern
        always_comb lane_out[i] = lane_in[idx_t'(i) ^ swap_eff];
        assign swapped[i*LANE_W +: LANE_W] = lane_out[i];
    end

    always_comb begin
        half_sel  = idx[0] ^ ctl_act.big_end;
        lane_sel  = idx ^ {IDX_W{ctl_act.big_end}};
        half_pick = half_sel ? swapped[HALF_W +: HALF_W] : swapped[0 +: HALF_W];
        lane_pick = lane_out[lane_sel];
        case (ctl_act.size)
            SZ_WORD: rd_data = {{(LONG_W-HALF_W){1'b0}}, half_pick};
            SZ_BYTE: rd_data = {{(LONG_W-LANE_W){1'b0}}, lane_pick};
            SZ_MBOX: rd_data = mbox_q;
            default: rd_data = swapped;
        endcase
    end

endmodule

// File: rtl/bmatch_rd_port.sv
module bmatch_rd_port
    import bmrd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        size_sel,
    input  logic              big_end,
    input  logic [1:0]        swap_sel,
    input  logic              rd_en,
    input  logic [LONG_W-1:0] fifo_q,
    input  logic [LONG_W-1:0] mbox_q,
    output logic [LONG_W-1:0] rd_data,
    output logic              fifo_pop,
    output logic              mbox_rd
);

    ctl_t  ctl_act;
    idx_t  idx;
    swap_t swap_eff;

    bmrd_ctl_sample u_ctl (
        .clk      (clk),
        .rst      (rst),
        .size_sel (size_sel),
        .big_end  (big_end),
        .ctl_act  (ctl_act)
    );

    bmrd_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .rd_en    (rd_en),
        .ctl_act  (ctl_act),
        .swap_sel (swap_t'(swap_sel)),
        .idx      (idx),
        .swap_eff (swap_eff),
        .fifo_pop (fifo_pop),
        .mbox_rd  (mbox_rd)
    );

    bmrd_lane_mux u_mux (
        .fifo_q   (fifo_q),
        .mbox_q   (mbox_q),
        .swap_eff (swap_eff),
        .ctl_act  (ctl_act),
        .idx      (idx),
        .rd_data  (rd_data)
    );

    // R9: a mailbox access and a FIFO pop never coincide
    p_mbox_excl_r9: assert property (@(posedge clk) disable iff (rst)
        mbox_rd |-> !fifo_pop);

    // R10: neither strobe without a read
    p_strobe_needs_rd_r10: assert property (@(posedge clk) disable iff (rst)
        (fifo_pop || mbox_rd) |-> rd_en);

endmodule

// File: tb/sim_bmatch_rd_port.sv
module sim_bmatch_rd_port;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  size_sel = 2'b00;
    logic        big_end = 1'b0;
    logic [1:0]  swap_sel = 2'b00;
    logic        rd_en = 1'b0;
    logic [35:0] fifo_q = '0;
    logic [35:0] mbox_q = '0;
    logic [35:0] rd_data;
    logic        fifo_pop;
    logic        mbox_rd;

    int n_chk = 0;
    int n_bad = 0;

    // bench model of the settings in force
    logic [1:0] m_size = 2'b00;
    logic       m_be = 1'b0;
    logic [1:0] m_idx = 2'b00;
    logic [1:0] m_swap = 2'b00;

    always #4 clk = ~clk;   // 125 MHz

    bmatch_rd_port u0 (
        .clk(clk), .rst(rst), .size_sel(size_sel), .big_end(big_end),
        .swap_sel(swap_sel), .rd_en(rd_en), .fifo_q(fifo_q), .mbox_q(mbox_q),
        .rd_data(rd_data), .fifo_pop(fifo_pop), .mbox_rd(mbox_rd)
    );

    function automatic logic [35:0] rnd36();
        return {4'($urandom()), $urandom()};
    endfunction

    function automatic logic [1:0] last_of(input logic [1:0] sz);
        return (sz == 2'b01) ? 2'd1 : (sz == 2'b10) ? 2'd3 : 2'd0;
    endfunction

    // expected read data per R3..R7
    function automatic logic [35:0] exp_out(input logic [35:0] q, input logic [1:0] sw,
                                            input logic [1:0] sz, input logic be,
                                            input logic [1:0] ix);
        logic [35:0] s;
        logic [1:0]  ln;
        logic        h;
        for (int i = 0; i < 4; i++) s[i*9 +: 9] = q[(i ^ int'(sw))*9 +: 9];
        h  = ix[0] ^ be;
        ln = be ? (2'd3 - ix) : ix;
        case (sz)
            2'b01:   return {18'b0, s[h*18 +: 18]};
            2'b10:   return {27'b0, s[ln*9 +: 9]};
            default: return s;
        endcase
    endfunction

    task automatic check(input string req, input logic [35:0] got, input logic [35:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
        end
    endtask

    task automatic idle_cycles(input int n, input string req);
        rd_en = 1'b0;
        for (int k = 0; k < n; k++) begin
            #2;
            check(req, {34'b0, fifo_pop, mbox_rd}, 36'b0);
            @(posedge clk); #1;
        end
    endtask

    task automatic set_mode(input logic [1:0] sz, input logic be);
        size_sel = sz;
        big_end  = be;
        idle_cycles(2, "R10 idle during mode change");
        m_size = sz;
        m_be   = be;
    endtask

    // one read with the model's expectation; called at posedge+1
    task automatic do_read(input logic [1:0] sw, input string req);
        logic [35:0] e;
        logic        ep;
        logic [1:0]  use_sw;
        rd_en    = 1'b1;
        swap_sel = sw;
        #2;
        if (m_size == 2'b11) begin
            check({req, " R9 mailbox data"}, rd_data, mbox_q);
            check({req, " R9 strobes"}, {34'b0, fifo_pop, mbox_rd}, 36'd1);
        end else begin
            use_sw = (m_idx == 2'd0) ? sw : m_swap;
            e  = exp_out(fifo_q, use_sw, m_size, m_be, m_idx);
            ep = (m_idx >= last_of(m_size));
            check({req, " data"}, rd_data, e);
            check({req, " pop"}, {34'b0, fifo_pop, mbox_rd}, {34'b0, ep, 1'b0});
            if (m_idx == 2'd0) m_swap = sw;
            m_idx = ep ? 2'd0 : m_idx + 2'd1;
        end
        @(posedge clk); #1;
        rd_en = 1'b0;
        if (fifo_pop === 1'b0 && m_size != 2'b11 && m_idx == 2'd0) fifo_q = rnd36();
        mbox_q = rnd36();
    endtask

    task automatic do_reset(input logic [1:0] sz_hold);
        rst = 1'b1; rd_en = 1'b0; size_sel = sz_hold; big_end = 1'b1;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        m_size = 2'b00; m_be = 1'b0; m_idx = 2'd0; m_swap = 2'd0;
    endtask

    initial begin
        #1000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'h1F2E3D4C));
        fifo_q = rnd36();
        mbox_q = rnd36();

        // R1 + R2: byte requested at reset and right after; two long reads first
        do_reset(2'b10);
        #2 check("R1 idle strobes after reset", {34'b0, fifo_pop, mbox_rd}, 36'b0);
        @(posedge clk); #1;
        do_reset(2'b10);
        size_sel = 2'b10; big_end = 1'b0;
        do_read(2'b00, "R1 R2 first read still long");
        do_read(2'b11, "R2 second read still long");
        m_size = 2'b10;
        do_read(2'b00, "R2 byte in force lane0");

        // directed swap patterns in long mode (R3, R7)
        set_mode(2'b00, 1'b0);
        fifo_q = {9'h1D3, 9'h0C2, 9'h1B1, 9'h0A0};
        do_read(2'b00, "R3 R7 no swap");
        fifo_q = {9'h1D3, 9'h0C2, 9'h1B1, 9'h0A0};
        do_read(2'b11, "R7 full reverse");
        fifo_q = {9'h1D3, 9'h0C2, 9'h1B1, 9'h0A0};
        do_read(2'b10, "R7 half exchange");
        fifo_q = {9'h1D3, 9'h0C2, 9'h1B1, 9'h0A0};
        do_read(2'b01, "R7 lanes within halves");

        // word both orders (R4, R6), swap change mid-word (R8)
        set_mode(2'b01, 1'b0);
        do_read(2'b10, "R4 word first");
        do_read(2'b00, "R4 R8 word second");
        set_mode(2'b01, 1'b1);
        do_read(2'b01, "R6 word upper first");
        do_read(2'b11, "R6 R8 word lower second");

        // byte, big-endian, mailbox inserted mid-word (R5, R6, R8, R9, R10)
        set_mode(2'b10, 1'b1);
        do_read(2'b11, "R5 R6 byte lane3 first");
        set_mode(2'b11, 1'b1);
        do_read(2'b00, "R9 mailbox between bytes");
        set_mode(2'b10, 1'b1);
        do_read(2'b01, "R9 R8 byte resumes");
        do_read(2'b10, "R5 byte third");
        do_read(2'b00, "R5 byte fourth pops");

        // reset in the middle of a byte word (R1)
        do_read(2'b10, "R5 partial before reset");
        do_reset(2'b00);
        do_read(2'b01, "R1 long after mid-word reset");

        // constrained random mix
        for (int it = 0; it < 400; it++) begin
            logic [1:0] sz;
            int         nrd;
            sz  = ($urandom_range(0, 9) == 0) ? 2'b11 : 2'($urandom_range(0, 2));
            set_mode(sz, 1'($urandom()));
            nrd = $urandom_range(1, 6);
            for (int r = 0; r < nrd; r++) begin
                if ($urandom_range(0, 4) == 0) idle_cycles(1, "R10 random idle");
                do_read(2'($urandom()), "R3-R9 random");
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule